// File: doc/BRIEF.md
# NAND Flash Page Store

This block is the storage side of a small NAND flash model. It holds `NUM_PAGES` rows. Each row has a main area of `PAGE_BYTES` bytes and a spare area of `PAGE_BYTES/32` bytes, so a row is `ROW = PAGE_BYTES + PAGE_BYTES/32` bytes long. Rows are grouped into erase blocks of `2**ERASE_SHIFT` pages.

A command decoder placed in front of the block drives its request pins:
- A setup pulse empties the fill buffer, and each data strobe then appends one byte to it.
- A program request merges the buffered bytes into a row. Because the data is ANDed into what is already stored, a program can clear bits but never set them.
- An erase request sets a whole block back to 0xFF.
- A load request copies a row into a read buffer. The decoder then reads that buffer byte by byte.

While an operation runs, a busy flag is raised and every request is ignored. A status byte reports three things: whether the write-protect input is released, whether the block is ready, and whether the last program failed because the array was protected.

Top module: `nand_flash_store`

## Requirements
- R1: After power-up and reset, `busy_o` is 0, `status_o` reads 0xC0 while `wp_n_i` is high, and every byte of every row (main and spare) reads 0xFF.
- R2: A `setup_i` pulse empties the fill buffer. Each `data_vld_i` cycle after that appends `data_i`. Bytes beyond `ROW` are discarded, and the buffer keeps its contents across program commits.
- R3: A program ANDs buffered byte k into row `row_i` at column `col_i + offset + k`, where offset is the pending offset. Bytes whose column would reach `ROW` or beyond are dropped.
- R4: `ofs_set_i` loads the pending offset from `ofs_val_i`. Every program request that is accepted on an in-range row clears the pending offset back to 0.
- R5: A program while `wp_n_i` is low leaves the array unchanged, does not raise busy, and sets `status_o` bit 0. The next program that does run clears that bit.
- R6: An erase keeps only the low `8*erase_nbytes_i` bits of `erase_addr_i` as the page index. It rounds that index down to a multiple of `2**ERASE_SHIFT` and writes 0xFF to every byte of every page in that block. Other blocks keep their contents.
- R7: An erase while `wp_n_i` is low has no effect on the array and does not raise busy.
- R8: A program, erase or load whose page index is `NUM_PAGES` or larger is ignored. Busy stays 0, and neither the array nor the read buffer changes.
- R9: `busy_o` rises at the clock edge that accepts a request. It stays high for exactly `2*ROW+HOLD_CYCLES` cycles for a program, `ROW*2**ERASE_SHIFT+HOLD_CYCLES` cycles for an erase, and `ROW+1+HOLD_CYCLES` cycles for a load. `status_o` bit 6 is the inverse of busy, and bit 7 is `wp_n_i` registered.
- R10: While busy, requests, `setup_i`, `ofs_set_i` and data strobes are ignored.
- R11: A load copies a whole row into the read buffer. `rd_data_o` returns the byte at `rd_idx_i` one clock edge after the index is applied.
- R12: When requests arrive in the same cycle, program wins over erase, and erase wins over load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wp_n_i | input | 1 | High = array unprotected |
| setup_i | input | 1 | Empty the fill buffer |
| data_vld_i | input | 1 | Append `data_i` to the fill buffer |
| data_i | input | 8 | Program data byte |
| ofs_set_i | input | 1 | Load the pending column offset |
| ofs_val_i | input | CW | Pending column offset value |
| prog_i | input | 1 | Program request |
| erase_i | input | 1 | Erase request |
| load_i | input | 1 | Load request |
| col_i | input | CW | Program start column |
| row_i | input | ROW_AW | Page index for program and load |
| erase_addr_i | input | EADDR_W | Raw row address bytes for erase |
| erase_nbytes_i | input | 2 | Number of erase address bytes received |
| rd_idx_i | input | CW | Read-buffer byte index |
| rd_data_o | output | 8 | Read-buffer byte (registered) |
| busy_o | output | 1 | Operation in progress |
| status_o | output | 8 | {unprotected, ready, 5'b0, error} |

## Verification
Every result lands at a fixed cycle count after its stimulus:
- A read-buffer byte appears one edge after its index is applied. The monitor therefore records at each rising edge whether an index was driven, and compares `rd_data_o` two nanoseconds after that edge.
- Busy is counted on falling edges from the first falling edge after the accepting rising edge. The count must equal the R9 formula exactly. An ignored request must show a count of zero.
- Status bits are sampled one full cycle after the input or request that changes them. A separate read-back of the row, through a load, shows each array effect.

// File: rtl/nand_pkg.sv
package nand_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_PROG, ST_ERASE, ST_LOAD, ST_HOLD} seq_st_e;
  localparam logic [7:0] BYTE_ERASED = 8'hFF;
endpackage

// File: rtl/nand_sdp_ram.sv
module nand_sdp_ram #(
  parameter int DEPTH = 66,
  parameter int AW = 7,
  parameter logic [7:0] FILL = 8'hFF
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = FILL;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/nand_pgbuf.sv
module nand_pgbuf #(
  parameter int ROW = 66,
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          busy_i,
  input  logic          setup_i,
  input  logic          vld_i,
  input  logic [7:0]    din_i,
  input  logic [CW-1:0] ridx_i,
  output logic [7:0]    rdata_o,
  output logic [CW:0]   len_o
);
  localparam logic [CW:0] ROW_C = (CW+1)'(ROW);

  logic [CW:0] cnt_q;
  logic        wr;

  assign wr = vld_i && !busy_i && !setup_i && (cnt_q < ROW_C);

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else if (!busy_i && setup_i) cnt_q <= '0;
    else if (wr) cnt_q <= cnt_q + 1'b1;
  end

  nand_sdp_ram #(.DEPTH(ROW), .AW(CW), .FILL(8'h00)) u_ram (
    .clk(clk), .we(wr), .waddr(cnt_q[CW-1:0]), .wdata(din_i),
    .raddr(ridx_i), .rdata(rdata_o)
  );

  assign len_o = cnt_q;

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst) cnt_q <= ROW_C);
  // R10
  buf_frozen_chk: assert property (@(posedge clk) disable iff (rst) busy_i |=> $stable(cnt_q));
endmodule

// File: rtl/nand_op_seq.sv
module nand_op_seq
  import nand_pkg::*;
#(
  parameter int ROW = 66,
  parameter int CW = 7,
  parameter int NUM_PAGES = 32,
  parameter int ERASE_SHIFT = 4,
  parameter int HOLD_CYCLES = 3,
  parameter int ROW_AW = 16,
  parameter int EADDR_W = 24,
  parameter int MW = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wp_n_i,
  input  logic               ofs_set_i,
  input  logic [CW-1:0]      ofs_val_i,
  input  logic               prog_i,
  input  logic               erase_i,
  input  logic               load_i,
  input  logic [CW-1:0]      col_i,
  input  logic [ROW_AW-1:0]  row_i,
  input  logic [EADDR_W-1:0] erase_addr_i,
  input  logic [1:0]         erase_nbytes_i,
  input  logic [CW:0]        buf_len_i,
  input  logic [7:0]         buf_rdata_i,
  output logic [CW-1:0]      buf_ridx_o,
  output logic               arr_we_o,
  output logic [MW-1:0]      arr_waddr_o,
  output logic [7:0]         arr_wdata_o,
  output logic [MW-1:0]      arr_raddr_o,
  input  logic [7:0]         arr_rdata_i,
  output logic               rb_we_o,
  output logic [CW-1:0]      rb_waddr_o,
  output logic [7:0]         rb_wdata_o,
  output logic               busy_o,
  output logic               err_o,
  output logic               wp_o
);
  localparam int PW = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1;
  localparam int BLK = 1 << ERASE_SHIFT;
  localparam int CNTW = $clog2(ROW * BLK + 2 * ROW + HOLD_CYCLES + 2);
  localparam logic [CNTW-1:0] PROG_LAST  = CNTW'(2 * ROW - 1);
  localparam logic [CNTW-1:0] ERASE_LAST = CNTW'(ROW * BLK - 1);
  localparam logic [CNTW-1:0] LOAD_LAST  = CNTW'(ROW);
  localparam logic [CNTW-1:0] HOLD_LAST  = CNTW'(HOLD_CYCLES - 1);
  localparam logic [ROW_AW-1:0]  NP_R = ROW_AW'(NUM_PAGES);
  localparam logic [EADDR_W-1:0] NP_E = EADDR_W'(NUM_PAGES);
  localparam logic [PW-1:0]      BLK_MASK = ~PW'(BLK - 1);

  seq_st_e           st_q;
  logic [CNTW-1:0]   cnt_q;
  logic [MW-1:0]     base_q;
  logic [CW:0]       start_q, len_q;
  logic [CW-1:0]     ofs_q;
  logic              err_q, wp_q;

  logic [EADDR_W-1:0] emask, ekeep;
  logic [PW-1:0]      epage;
  logic               row_ok, erase_ok;
  logic [CW-1:0]      col;
  logic [CW:0]        rel;
  logic               in_rng;

  always_comb begin
    case (erase_nbytes_i)
      2'd0:    emask = '0;
      2'd1:    emask = EADDR_W'(8'hFF);
      2'd2:    emask = EADDR_W'(16'hFFFF);
      default: emask = '1;
    endcase
  end

  assign ekeep    = erase_addr_i & emask;
  assign epage    = ekeep[PW-1:0] & BLK_MASK;
  assign row_ok   = row_i < NP_R;
  assign erase_ok = ekeep < NP_E;

  assign col    = cnt_q[CW:1];
  assign rel    = {1'b0, col} - start_q;
  assign in_rng = ({1'b0, col} >= start_q) && (rel < len_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      base_q  <= '0;
      start_q <= '0;
      len_q   <= '0;
      ofs_q   <= '0;
      err_q   <= 1'b0;
      wp_q    <= 1'b0;
    end else begin
      wp_q <= wp_n_i;
      case (st_q)
        ST_IDLE: begin
          cnt_q <= '0;
          if (prog_i) begin
            if (row_ok) begin
              ofs_q <= '0;
              if (wp_n_i) begin
                st_q    <= ST_PROG;
                base_q  <= MW'(row_i[PW-1:0]) * MW'(ROW);
                start_q <= {1'b0, col_i} + {1'b0, ofs_q};
                len_q   <= buf_len_i;
                err_q   <= 1'b0;
              end else begin
                err_q <= 1'b1;
              end
            end
          end else begin
            if (ofs_set_i) ofs_q <= ofs_val_i;
            if (erase_i) begin
              if (erase_ok && wp_n_i) begin
                st_q   <= ST_ERASE;
                base_q <= MW'(epage) * MW'(ROW);
              end
            end else if (load_i && row_ok) begin
              st_q   <= ST_LOAD;
              base_q <= MW'(row_i[PW-1:0]) * MW'(ROW);
            end
          end
        end
        ST_PROG: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == PROG_LAST) begin st_q <= ST_HOLD; cnt_q <= '0; end
        end
        ST_ERASE: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == ERASE_LAST) begin st_q <= ST_HOLD; cnt_q <= '0; end
        end
        ST_LOAD: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LOAD_LAST) begin st_q <= ST_HOLD; cnt_q <= '0; end
        end
        default: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == HOLD_LAST) begin st_q <= ST_IDLE; cnt_q <= '0; end
        end
      endcase
    end
  end

  always_comb begin
    arr_we_o    = 1'b0;
    arr_waddr_o = base_q;
    arr_wdata_o = BYTE_ERASED;
    arr_raddr_o = base_q;
    rb_we_o     = 1'b0;
    rb_waddr_o  = CW'(cnt_q - 1'b1);
    rb_wdata_o  = arr_rdata_i;
    case (st_q)
      ST_PROG: begin
        arr_raddr_o = base_q + MW'(col);
        arr_waddr_o = base_q + MW'(col);
        arr_we_o    = cnt_q[0];
        arr_wdata_o = arr_rdata_i & (in_rng ? buf_rdata_i : BYTE_ERASED);
      end
      ST_ERASE: begin
        arr_we_o    = 1'b1;
        arr_waddr_o = base_q + MW'(cnt_q);
      end
      ST_LOAD: begin
        arr_raddr_o = base_q + MW'(cnt_q);
        rb_we_o     = (cnt_q != '0);
      end
      default: ;
    endcase
  end

  assign buf_ridx_o = rel[CW-1:0];
  assign busy_o     = (st_q != ST_IDLE);
  assign err_o      = err_q;
  assign wp_o       = wp_q;

  // R9
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(prog_i || erase_i || load_i));
  // R3
  prog_clear_only_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_PROG && arr_we_o) |-> ((arr_wdata_o & ~arr_rdata_i) == 8'h00));
  // R5
  prot_prog_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE && prog_i && !wp_n_i && row_i < NP_R) |=> (err_q && !busy_o));
  // R8
  range_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE && prog_i && row_i >= NP_R) |=> !busy_o);
endmodule

// File: rtl/nand_flash_store.sv
module nand_flash_store #(
  parameter int PAGE_BYTES = 64,
  parameter int NUM_PAGES = 32,
  parameter int ERASE_SHIFT = 4,
  parameter int HOLD_CYCLES = 3,
  parameter int ROW_AW = 16,
  parameter int EADDR_W = 24,
  localparam int ROW = PAGE_BYTES + PAGE_BYTES / 32,
  localparam int CW = $clog2(ROW),
  localparam int MEM = NUM_PAGES * ROW,
  localparam int MW = $clog2(MEM)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wp_n_i,
  input  logic               setup_i,
  input  logic               data_vld_i,
  input  logic [7:0]         data_i,
  input  logic               ofs_set_i,
  input  logic [CW-1:0]      ofs_val_i,
  input  logic               prog_i,
  input  logic               erase_i,
  input  logic               load_i,
  input  logic [CW-1:0]      col_i,
  input  logic [ROW_AW-1:0]  row_i,
  input  logic [EADDR_W-1:0] erase_addr_i,
  input  logic [1:0]         erase_nbytes_i,
  input  logic [CW-1:0]      rd_idx_i,
  output logic [7:0]         rd_data_o,
  output logic               busy_o,
  output logic [7:0]         status_o
);
  logic          busy, err, wp_q;
  logic [CW:0]   buf_len;
  logic [7:0]    buf_rdata;
  logic [CW-1:0] buf_ridx;
  logic          arr_we;
  logic [MW-1:0] arr_waddr, arr_raddr;
  logic [7:0]    arr_wdata, arr_rdata;
  logic          rb_we;
  logic [CW-1:0] rb_waddr;
  logic [7:0]    rb_wdata;

  nand_pgbuf #(.ROW(ROW), .CW(CW)) u_pgbuf (
    .clk(clk), .rst(rst), .busy_i(busy), .setup_i(setup_i), .vld_i(data_vld_i),
    .din_i(data_i), .ridx_i(buf_ridx), .rdata_o(buf_rdata), .len_o(buf_len)
  );

  nand_op_seq #(
    .ROW(ROW), .CW(CW), .NUM_PAGES(NUM_PAGES), .ERASE_SHIFT(ERASE_SHIFT),
    .HOLD_CYCLES(HOLD_CYCLES), .ROW_AW(ROW_AW), .EADDR_W(EADDR_W), .MW(MW)
  ) u_seq (
    .clk(clk), .rst(rst), .wp_n_i(wp_n_i), .ofs_set_i(ofs_set_i), .ofs_val_i(ofs_val_i),
    .prog_i(prog_i), .erase_i(erase_i), .load_i(load_i), .col_i(col_i), .row_i(row_i),
    .erase_addr_i(erase_addr_i), .erase_nbytes_i(erase_nbytes_i),
    .buf_len_i(buf_len), .buf_rdata_i(buf_rdata), .buf_ridx_o(buf_ridx),
    .arr_we_o(arr_we), .arr_waddr_o(arr_waddr), .arr_wdata_o(arr_wdata),
    .arr_raddr_o(arr_raddr), .arr_rdata_i(arr_rdata),
    .rb_we_o(rb_we), .rb_waddr_o(rb_waddr), .rb_wdata_o(rb_wdata),
    .busy_o(busy), .err_o(err), .wp_o(wp_q)
  );

  nand_sdp_ram #(.DEPTH(MEM), .AW(MW), .FILL(8'hFF)) u_array (
    .clk(clk), .we(arr_we), .waddr(arr_waddr), .wdata(arr_wdata),
    .raddr(arr_raddr), .rdata(arr_rdata)
  );

  nand_sdp_ram #(.DEPTH(ROW), .AW(CW), .FILL(8'hFF)) u_rdbuf (
    .clk(clk), .we(rb_we), .waddr(rb_waddr), .wdata(rb_wdata),
    .raddr(rd_idx_i), .rdata(rd_data_o)
  );

  assign busy_o   = busy;
  assign status_o = {wp_q, ~busy, 5'b00000, err};
endmodule

// File: tb/sim_nand_flash_store.sv
module sim_nand_flash_store;
  localparam int ROW = 66;
  localparam int NP = 32;
  localparam int BLK = 16;
  localparam int HOLD = 3;
  localparam int PB = 2 * ROW + HOLD;
  localparam int EB = ROW * BLK + HOLD;
  localparam int LB = ROW + 1 + HOLD;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wp_n_i = 1'b1, setup_i = 1'b0, data_vld_i = 1'b0, ofs_set_i = 1'b0;
  logic prog_i = 1'b0, erase_i = 1'b0, load_i = 1'b0;
  logic [7:0] data_i = '0;
  logic [6:0] ofs_val_i = '0, col_i = '0, rd_idx_i = '0;
  logic [15:0] row_i = '0;
  logic [23:0] erase_addr_i = '0;
  logic [1:0] erase_nbytes_i = '0;
  logic [7:0] rd_data_o, status_o;
  logic busy_o;

  always #10 clk = ~clk;

  nand_flash_store u0 (
    .clk(clk), .rst(rst), .wp_n_i(wp_n_i), .setup_i(setup_i), .data_vld_i(data_vld_i),
    .data_i(data_i), .ofs_set_i(ofs_set_i), .ofs_val_i(ofs_val_i), .prog_i(prog_i),
    .erase_i(erase_i), .load_i(load_i), .col_i(col_i), .row_i(row_i),
    .erase_addr_i(erase_addr_i), .erase_nbytes_i(erase_nbytes_i), .rd_idx_i(rd_idx_i),
    .rd_data_o(rd_data_o), .busy_o(busy_o), .status_o(status_o)
  );

  typedef struct { logic [7:0] v; string tag; } exp_t;
  exp_t sb[$];
  logic [7:0] exp_mem [NP*ROW];
  logic [7:0] tb_buf[$];
  int tb_ofs = 0;
  int checks = 0, errors = 0;
  logic rd_vld_tb = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: read-buffer byte due one edge after its index
  always @(posedge clk) begin : mon
    logic v;
    exp_t e;
    v = rd_vld_tb;
    #2;
    if (v) begin
      if (sb.size() == 0) chk("R11 empty scoreboard", 1, 0);
      else begin
        e = sb.pop_front();
        chk(e.tag, int'(rd_data_o), int'(e.v));
      end
    end
  end

  task automatic do_setup();
    setup_i = 1'b1; @(negedge clk); setup_i = 1'b0;
    tb_buf.delete();
  endtask

  task automatic put_byte(input logic [7:0] b);
    data_i = b; data_vld_i = 1'b1; @(negedge clk); data_vld_i = 1'b0;
    if (tb_buf.size() < ROW) tb_buf.push_back(b);
  endtask

  task automatic run_req(input logic p, input logic e, input logic l, input int row,
                         input int col, input logic [23:0] ea, input logic [1:0] en,
                         input int expb, input string tag);
    int n;
    prog_i = p; erase_i = e; load_i = l;
    row_i = 16'(row); col_i = 7'(col); erase_addr_i = ea; erase_nbytes_i = en;
    @(negedge clk);
    prog_i = 1'b0; erase_i = 1'b0; load_i = 1'b0;
    n = 0;
    while (busy_o) begin n++; @(negedge clk); end
    chk(tag, n, expb);
  endtask

  task automatic model_prog(input int row, input int col);
    for (int k = 0; k < tb_buf.size(); k++) begin
      int c;
      c = col + tb_ofs + k;
      if (c < ROW) exp_mem[row*ROW + c] = exp_mem[row*ROW + c] & tb_buf[k];
    end
    tb_ofs = 0;
  endtask

  task automatic model_erase(input int page);
    int b;
    b = page - (page % BLK);
    for (int i = b * ROW; i < (b + BLK) * ROW; i++) exp_mem[i] = 8'hFF;
  endtask

  task automatic prog(input int row, input int col, input string tag);
    run_req(1'b1, 1'b0, 1'b0, row, col, '0, 2'd0, PB, tag);
    model_prog(row, col);
  endtask

  task automatic load(input int row);
    run_req(1'b0, 1'b0, 1'b1, row, 0, '0, 2'd0, LB, "R9 load busy");
  endtask

  task automatic read_page(input int row, input string tag);
    for (int c = 0; c < ROW; c++) begin
      rd_idx_i = 7'(c);
      rd_vld_tb = 1'b1;
      sb.push_back('{exp_mem[row*ROW + c], tag});
      @(negedge clk);
    end
    rd_vld_tb = 1'b0;
  endtask

  task automatic check_row(input int row, input string tag);
    load(row);
    read_page(row, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NP*ROW; i++) exp_mem[i] = 8'hFF;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 busy after reset", int'(busy_o), 0);
    chk("R1 R9 status after reset", int'(status_o), 8'hC0);
    check_row(5, "R1 R11 erased at power-up");

    // R3 basic program and AND merge
    do_setup();
    put_byte(8'hA5); put_byte(8'h3C); put_byte(8'h0F); put_byte(8'hF0);
    prog(5, 10, "R9 program busy");
    check_row(5, "R3 first program");
    do_setup();
    put_byte(8'h0F); put_byte(8'hFF); put_byte(8'hF0); put_byte(8'h00);
    prog(5, 11, "R9 program busy");
    check_row(5, "R3 AND merge");

    // R4 pending offset used once
    ofs_val_i = 7'd8; ofs_set_i = 1'b1; @(negedge clk); ofs_set_i = 1'b0;
    tb_ofs = 8;
    do_setup(); put_byte(8'h11); put_byte(8'h22);
    prog(6, 20, "R4 offset program");
    do_setup(); put_byte(8'h44);
    prog(6, 20, "R4 offset cleared");
    check_row(6, "R4 offset placement");

    // R2 buffer overflow, R3 row end
    do_setup();
    for (int i = 0; i < 70; i++) put_byte(8'(i + 1));
    chk("R2 model keeps row bytes", tb_buf.size(), ROW);
    prog(7, 0, "R2 full buffer program");
    prog(8, 60, "R3 retained buffer near row end");
    check_row(7, "R2 buffer content");
    check_row(8, "R3 row end clipping");

    // R5 protected program
    wp_n_i = 1'b0; @(negedge clk);
    do_setup(); put_byte(8'h00);
    run_req(1'b1, 1'b0, 1'b0, 9, 0, '0, 2'd0, 0, "R5 protected program no busy");
    tb_ofs = 0;
    chk("R5 error status", int'(status_o), 8'h41);
    check_row(9, "R5 array unchanged");
    wp_n_i = 1'b1; @(negedge clk);
    do_setup(); put_byte(8'h7E);
    prog(9, 0, "R9 program busy");
    chk("R5 error cleared", int'(status_o), 8'hC0);
    check_row(9, "R5 program after release");

    // R6 erase with alignment and byte masking
    do_setup(); put_byte(8'h00);
    prog(16, 0, "R9 program busy");
    prog(31, 65, "R9 program busy");
    prog(15, 3, "R9 program busy");
    run_req(1'b0, 1'b1, 1'b0, 0, 0, 24'h000013, 2'd1, EB, "R6 R9 erase busy");
    model_erase(19);
    check_row(16, "R6 block start erased");
    check_row(31, "R6 block end erased");
    check_row(15, "R6 other block kept");
    run_req(1'b0, 1'b1, 1'b0, 0, 0, 24'hFF0005, 2'd1, EB, "R6 masked erase busy");
    model_erase(5);
    check_row(5, "R6 masked address erased");

    // R7 protected erase
    do_setup(); put_byte(8'h3C);
    prog(20, 2, "R9 program busy");
    wp_n_i = 1'b0; @(negedge clk);
    run_req(1'b0, 1'b1, 1'b0, 0, 0, 24'h000014, 2'd1, 0, "R7 protected erase no busy");
    chk("R7 status after protected erase", int'(status_o), 8'h40);
    check_row(20, "R7 array kept");
    wp_n_i = 1'b1; @(negedge clk);

    // R8 out of range
    run_req(1'b1, 1'b0, 1'b0, 40, 0, '0, 2'd0, 0, "R8 program out of range");
    run_req(1'b0, 1'b1, 1'b0, 0, 0, 24'h000040, 2'd2, 0, "R8 erase out of range");
    run_req(1'b0, 1'b0, 1'b1, 33, 0, '0, 2'd0, 0, "R8 load out of range");
    read_page(20, "R8 read buffer kept");

    // R10 activity while busy ignored
    do_setup(); put_byte(8'h01);
    prog_i = 1'b1; row_i = 16'd10; col_i = 7'd0;
    @(negedge clk);
    row_i = 16'd11; data_i = 8'h00; data_vld_i = 1'b1;
    @(negedge clk);
    prog_i = 1'b0; data_vld_i = 1'b0;
    while (busy_o) @(negedge clk);
    model_prog(10, 0);
    check_row(10, "R10 first program");
    check_row(11, "R10 request during busy ignored");
    prog(13, 0, "R9 program busy");
    check_row(13, "R10 data during busy ignored");

    // R12 priority
    do_setup(); put_byte(8'h5A);
    run_req(1'b1, 1'b1, 1'b1, 12, 1, 24'h000000, 2'd1, PB, "R12 program wins");
    model_prog(12, 1);
    run_req(1'b0, 1'b1, 1'b1, 12, 0, 24'h000010, 2'd1, EB, "R12 erase wins over load");
    model_erase(16);
    check_row(12, "R12 program applied");
    check_row(16, "R12 erase applied");

    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule